// File: doc/BRIEF.md
# Phase Difference Charge Pulse Generator

This block drives the digital side of a charge-pump phase-to-voltage converter. A fast sampling clock resynchronises three slow inputs (a measurement gate, a two-level data signal and a reference clock). It also finds their edges. From these it produces a charge pulse, a discharge pulse, a capacitor-doubling control and a held result flag. The analog charge pump turns the width difference between the two pulses into a voltage.

A measurement is one gated conversion. Lowering the gate arms the block. After a guard interval it converts the first data edge of the selected polarity against the next reference-clock rising edge. Raising the gate returns every output to its rest condition. In the coefficient mode the data input has no effect, and the block emits a single reference pulse exactly one reference-clock period wide. A two-bit test select can steer either the internal pulses or the resynchronised comparator inputs onto two monitor pins. All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `pcp_gen`

## Requirements
- R1: After reset, chg_o, dis_o, dbl_cap_o, conv_valid_o, mon_a_o and mon_b_o are all 0. A rising edge on start_in ends the measurement. Within 3 sampling-clock edges, chg_o, dis_o and conv_valid_o are 0, even in the middle of a pulse.
- R2: polar_in = 0 selects the falling edge of data_in as the measured edge, and polar_in = 1 selects the rising edge. An edge of the other polarity has no effect. polar_in and coef_mode_in are captured when the start_in fall is detected.
- R3: If the active data edge comes before the reference rising edge, chg_o is high for as many sampling cycles as separate the two edges. If it comes after, dis_o is high for that many cycles. If both are seen in the same sampling cycle, neither pulse occurs. Every input change reaches the outputs 3 sampling-clock edges later.
- R4: Data edges are accepted only after the second rdclk_in rising edge that follows the start_in fall. Data edges seen earlier, including one in the same cycle as that second rising edge, are ignored.
- R5: Only the first accepted data edge is converted. No further pulse occurs until start_in rises and falls again.
- R6: conv_valid_o rises in the cycle after the pulse ends, or in the cycle after a coincident edge pair. It then stays high until start_in rises.
- R7: With coef_mode_in = 1, data_in is ignored. Once the block is armed, a single pulse runs from one rdclk_in rising edge to the next: chg_o if polar_in = 1, dis_o if polar_in = 0. dbl_cap_o is high from arming until start_in rises.
- R8: test_sel_in = 00 or 11 holds mon_a_o and mon_b_o at 0. Code 01 puts chg_o on mon_a_o and dis_o on mon_b_o. Code 10 puts the resynchronised rdclk_in on mon_a_o and the resynchronised data_in on mon_b_o.
- R9: chg_o and dis_o are never high in the same cycle, and neither is high while conv_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 8x the reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | Measurement gate; low arms, high resets |
| data_in | input | 1 | Two-level data signal being measured |
| rdclk_in | input | 1 | Reference clock; rising edges are the reference |
| polar_in | input | 1 | Active data edge: 0 falling, 1 rising; in coefficient mode, pulse sign |
| coef_mode_in | input | 1 | 1 selects the fixed one-period reference pulse |
| test_sel_in | input | 2 | Monitor routing select |
| chg_o | output | 1 | Charge pulse |
| dis_o | output | 1 | Discharge pulse |
| dbl_cap_o | output | 1 | Capacitor doubling control in coefficient mode |
| conv_valid_o | output | 1 | Held conversion-complete flag |
| mon_a_o | output | 1 | Test monitor A |
| mon_b_o | output | 1 | Test monitor B |

## Verification
Every input change reaches the state register 3 sampling edges later: two synchroniser flops, then the state update. Pulse widths therefore equal the input-edge spacing, and the gate rise clears the outputs within those 3 edges. The bench moves all inputs on the falling clock edge. It places each data edge a counted number of ticks after the gate fall, aligned to a known reference-clock phase, and queues the expected charge and discharge widths. A monitor sums the widths and compares them when conv_valid_o falls, so late extra pulses are also caught. Direct probes read the monitors, the held flag and the abort result at least 3 ticks after the stimulus that sets them.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_ARMED,
    ST_CHG,
    ST_DIS,
    ST_DONE
  } pcp_state_e;

  localparam logic [1:0] TM_OFF   = 2'b00;
  localparam logic [1:0] TM_PULSE = 2'b01;
  localparam logic [1:0] TM_INPUT = 2'b10;
endpackage

// File: rtl/pcp_sync.sv
module pcp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/pcp_edge.sv
module pcp_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/pcp_core.sv
module pcp_core
  import pcp_pkg::*;
#(
  parameter int GUARD_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_fall,
  input  logic start_rise,
  input  logic rd_rise,
  input  logic d_rise,
  input  logic d_fall,
  input  logic polar,
  input  logic coef,
  output logic chg,
  output logic dis,
  output logic dbl,
  output logic valid,
  output logic armed
);
  localparam int CW = (GUARD_EDGES > 1) ? $clog2(GUARD_EDGES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GUARD_EDGES - 1);

  pcp_state_e   state;
  logic [CW-1:0] gcnt;
  logic          polar_q;
  logic          coef_q;
  logic          act_edge;

  assign act_edge = polar_q ? d_rise : d_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gcnt    <= '0;
      polar_q <= 1'b0;
      coef_q  <= 1'b0;
    end else if (start_rise) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_fall) begin
          state   <= ST_GUARD;
          gcnt    <= '0;
          polar_q <= polar;
          coef_q  <= coef;
        end
        ST_GUARD: if (rd_rise) begin
          if (gcnt == CNT_LAST) state <= ST_ARMED;
          else                  gcnt  <= gcnt + 1'b1;
        end
        ST_ARMED: begin
          if (coef_q) begin
            if (rd_rise) state <= polar_q ? ST_CHG : ST_DIS;
          end else if (act_edge && rd_rise) state <= ST_DONE;
          else if (act_edge)                state <= ST_CHG;
          else if (rd_rise)                 state <= ST_DIS;
        end
        ST_CHG: if (rd_rise) state <= ST_DONE;
        ST_DIS: if (coef_q ? rd_rise : act_edge) state <= ST_DONE;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign chg   = (state == ST_CHG);
  assign dis   = (state == ST_DIS);
  assign valid = (state == ST_DONE);
  assign armed = (state == ST_ARMED);
  assign dbl   = coef_q && (state inside {ST_ARMED, ST_CHG, ST_DIS, ST_DONE});
endmodule

// File: rtl/pcp_testmux.sv
module pcp_testmux
  import pcp_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       chg,
  input  logic       dis,
  input  logic       rd_s,
  input  logic       d_s,
  output logic       mon_a,
  output logic       mon_b
);
  always_comb begin
    mon_a = 1'b0;
    mon_b = 1'b0;
    case (sel)
      TM_PULSE: begin mon_a = chg;  mon_b = dis; end
      TM_INPUT: begin mon_a = rd_s; mon_b = d_s; end
      default:  begin mon_a = 1'b0; mon_b = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pcp_gen.sv
module pcp_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_in,
  input  logic       data_in,
  input  logic       rdclk_in,
  input  logic       polar_in,
  input  logic       coef_mode_in,
  input  logic [1:0] test_sel_in,
  output logic       chg_o,
  output logic       dis_o,
  output logic       dbl_cap_o,
  output logic       conv_valid_o,
  output logic       mon_a_o,
  output logic       mon_b_o
);
  localparam int NIN = 3;
  localparam int IX_START = 0;
  localparam int IX_DATA  = 1;
  localparam int IX_RD    = 2;

  logic [NIN-1:0] raw_w, sync_w, rise_w, fall_w;
  logic           start_sync;
  logic           armed_w;

  assign raw_w = {rdclk_in, data_in, start_in};
  assign start_sync = sync_w[IX_START];

  pcp_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_w), .q_out(sync_w)
  );

  pcp_edge #(.W(NIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_w), .rise(rise_w), .fall(fall_w)
  );

  pcp_core #(.GUARD_EDGES(GUARD_EDGES)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start_fall(fall_w[IX_START]), .start_rise(rise_w[IX_START]),
    .rd_rise(rise_w[IX_RD]), .d_rise(rise_w[IX_DATA]), .d_fall(fall_w[IX_DATA]),
    .polar(polar_in), .coef(coef_mode_in),
    .chg(chg_o), .dis(dis_o), .dbl(dbl_cap_o), .valid(conv_valid_o), .armed(armed_w)
  );

  pcp_testmux u_mux (
    .sel(test_sel_in), .chg(chg_o), .dis(dis_o),
    .rd_s(sync_w[IX_RD]), .d_s(sync_w[IX_DATA]),
    .mon_a(mon_a_o), .mon_b(mon_b_o)
  );
endmodule

// File: rtl/pcp_chk.sv
module pcp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_s,
  input logic       armed,
  input logic       chg,
  input logic       dis,
  input logic       valid,
  input logic [1:0] tsel,
  input logic       mon_a,
  input logic       mon_b
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg && dis)); // R9

  AST_NO_PULSE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !chg && !dis); // R5

  AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> !chg && !dis && !valid); // R1

  AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chg) || $rose(dis)) |-> $past(armed)); // R4

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start_s) |=> valid); // R6

  AST_MON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b00) |-> !mon_a && !mon_b); // R8
endmodule

bind pcp_gen pcp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_s(start_sync), .armed(armed_w),
  .chg(chg_o), .dis(dis_o), .valid(conv_valid_o),
  .tsel(test_sel_in), .mon_a(mon_a_o), .mon_b(mon_b_o)
);

// File: tb/pcp_gen_tb_top.sv
`timescale 1ns/1ps
module pcp_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_in = 1'b1, data_in = 1'b1, rdclk_in = 1'b0;
  logic polar_in = 1'b0, coef_mode_in = 1'b0;
  logic [1:0] test_sel_in = 2'b00;
  logic chg_o, dis_o, dbl_cap_o, conv_valid_o, mon_a_o, mon_b_o;

  always #2.5 clk = ~clk;

  pcp_gen dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  int rd_ph = 0;
  int step = 0;
  bit finished = 0;
  int exp_c[$], exp_d[$];
  string exp_tag[$];

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sampling tick, inputs move on the falling edge; reference clock period 8 ticks
  task automatic tick();
    @(negedge clk);
    rd_ph = (rd_ph + 1) % 8;
    rdclk_in = (rd_ph < 4);
  endtask

  task automatic begin_meas(bit pol, bit coef, bit d0);
    polar_in = pol; coef_mode_in = coef; data_in = d0;
    tick(); tick();
    while (rd_ph != 2) tick();
    start_in = 1'b0;
    step = 0;
  endtask

  task automatic run_to(int s);
    while (step < s) begin tick(); step++; end
  endtask

  task automatic end_meas();
    start_in = 1'b1;
    for (int i = 0; i < 8; i++) tick();
  endtask

  task automatic push(int c, int d, string tag);
    exp_c.push_back(c); exp_d.push_back(d); exp_tag.push_back(tag);
  endtask

  // monitor: sums pulse widths per measurement, compares on flag fall
  int cw = 0, dw = 0;
  logic pv = 0, ps = 1;
  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (ps && !start_in) begin cw = 0; dw = 0; end
      if (chg_o) cw++;
      if (dis_o) dw++;
      if (pv && !conv_valid_o) begin
        if (exp_c.size() == 0) check(0, "R5 unexpected result", cw, -1);
        else begin
          string t;
          int ec, ed;
          ec = exp_c.pop_front(); ed = exp_d.pop_front(); t = exp_tag.pop_front();
          check(cw == ec, {t, " charge width"}, cw, ec);
          check(dw == ed, {t, " discharge width"}, dw, ed);
        end
      end
      pv = conv_valid_o;
      ps = start_in;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) tick();
    rst_n = 1'b1;
    tick(); tick();
    // R1 reset state
    check({chg_o, dis_o, dbl_cap_o, conv_valid_o, mon_a_o, mon_b_o} == 6'b0,
          "R1 reset outputs", {chg_o, dis_o, dbl_cap_o, conv_valid_o, mon_a_o, mon_b_o}, 0);

    // R3 data leads by 5, R5 later edges, R6 held flag
    begin_meas(0, 0, 1);
    push(5, 0, "R3 lead");
    run_to(17); data_in = 0;
    run_to(40);
    check(conv_valid_o == 1, "R6 flag held", conv_valid_o, 1);
    run_to(44); data_in = 1;
    run_to(48); data_in = 0;
    run_to(60);
    check(conv_valid_o == 1 && !chg_o && !dis_o, "R5 later edges ignored", conv_valid_o, 1);
    end_meas();
    check(conv_valid_o == 0, "R6 flag clears on gate rise", conv_valid_o, 0);

    // R3 data lags by 3
    begin_meas(0, 0, 1);
    push(0, 3, "R3 lag");
    run_to(25); data_in = 0;
    run_to(40); end_meas();

    // R3 coincident edges, rising polarity
    begin_meas(1, 0, 0);
    push(0, 0, "R3 coincident");
    run_to(22); data_in = 1;
    run_to(36);
    check(conv_valid_o == 1, "R3 coincident flag", conv_valid_o, 1);
    end_meas();

    // R2 wrong-polarity edge first
    begin_meas(1, 0, 1);
    push(2, 0, "R2 polarity");
    run_to(18); data_in = 0;
    run_to(20); data_in = 1;
    run_to(40); end_meas();

    // R4 edge inside guard ignored
    begin_meas(0, 0, 1);
    push(3, 0, "R4 guard");
    run_to(5);  data_in = 0;
    run_to(9);  data_in = 1;
    run_to(19); data_in = 0;
    run_to(40); end_meas();

    // R7 coefficient mode, charge direction, data toggling
    begin_meas(1, 1, 0);
    push(8, 0, "R7 coef plus");
    for (int s = 3; s < 45; s += 3) begin run_to(s); data_in = ~data_in; end
    check(dbl_cap_o == 1, "R7 double cap", dbl_cap_o, 1);
    end_meas();
    check(dbl_cap_o == 0, "R7 double cap clears", dbl_cap_o, 0);

    // R7 coefficient mode, discharge direction
    begin_meas(0, 1, 1);
    push(0, 8, "R7 coef minus");
    for (int s = 4; s < 45; s += 4) begin run_to(s); data_in = ~data_in; end
    end_meas();

    // R1 abort in the middle of a charge pulse
    begin_meas(0, 0, 1);
    run_to(16); data_in = 0;
    run_to(20);
    check(chg_o == 1, "R1 pulse running before abort", chg_o, 1);
    start_in = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check(!chg_o && !dis_o && !conv_valid_o, "R1 abort clears", {chg_o, dis_o, conv_valid_o}, 0);
    for (int i = 0; i < 6; i++) tick();

    // R8 monitor routing
    test_sel_in = 2'b10;
    data_in = 1; tick(); tick(); tick();
    check(mon_b_o == 1, "R8 data to monitor B", mon_b_o, 1);
    data_in = 0; tick(); tick(); tick();
    check(mon_b_o == 0, "R8 data low on monitor B", mon_b_o, 0);
    test_sel_in = 2'b01;
    begin_meas(0, 0, 1);
    push(6, 0, "R8 pulse monitor run");
    run_to(16); data_in = 0;
    run_to(20);
    check(mon_a_o == 1 && mon_b_o == 0, "R8 charge on monitor A", {mon_a_o, mon_b_o}, 2);
    run_to(40); end_meas();
    test_sel_in = 2'b11;
    tick();
    check(!mon_a_o && !mon_b_o, "R8 code 11 quiet", {mon_a_o, mon_b_o}, 0);
    test_sel_in = 2'b00;

    for (int i = 0; i < 10; i++) tick();
    check(exp_c.size() == 0, "R3 all results seen", exp_c.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule